// File: doc/BRIEF.md
# Interval Timer and Interrupt Register File

This block is a byte-wide bank of sixteen peripheral registers. A host reaches it over a simple strobe bus, and the register index comes from address bits 12:9. The bank holds two 16-bit down-counters that step on a tick. The tick is the input clock divided by six. Timer A has a reload latch, so its period can be programmed, and in periodic mode each wrap of timer A raises a flag. Timer B counts through the full 16-bit range and wraps without raising any flag.

An interrupt flag bank and an interrupt enable bank sit next to the timers. The single interrupt output follows the shift-event flag only; the timer flag does not drive it. Port, direction, shift, control and no-handshake port registers are plain storage. An external shift-complete pulse sets the shift-event flag, and the serial transfer itself lives outside the block.

Timer A mode is a two-state machine:
- QUIET: wraps raise no flag.
- PERIODIC: every wrap sets the timer flag.

QUIET goes to PERIODIC on a write to the auxiliary control register whose bits 7:6 are 01. PERIODIC goes back to QUIET on any auxiliary control write with another value in those bits. Both states leave the counters untouched.

Top module: `tick_timer_regfile`

## Requirements
- R1: The register index is `bus_addr[12:9]`, and the lower address bits are ignored. The plain-storage indices are:
  - 0: port B
  - 1: port A
  - 2: direction B
  - 3: direction A
  - 10: shift
  - 11: auxiliary control
  - 12: peripheral control
  - 15: port A without handshake

  A read of any of these returns the last byte written to it. Read data appears on `bus_rdata` one cycle after the read strobe.
- R2: After reset:
  - Both counters hold 0xFFFF.
  - The timer A latch reads 0x00 at indices 6 (low) and 7 (high), because it holds the 17-bit value 0x10000.
  - The flag bank (index 13), the enable bank (index 14) and `irq` are all zero.
- R3: Each counter decrements by one every six clock cycles. The first step lands on the sixth rising edge after reset is released.
- R4: Writing a counter low byte (index 4 for timer A, 8 for timer B) keeps the current high byte. Writing a counter high byte (index 5 or 9) keeps the current low byte.
- R5: A step taken from zero reloads the counter, so timer A's period equals its latch value:
  - Timer A reloads latch minus one.
  - Timer B reloads 0xFFFF.
  - A write to either latch byte clears latch bit 16.
- R6: While auxiliary control bits 7:6 are 01 (PERIODIC), each timer A wrap sets flag bit 6. In QUIET state a wrap leaves bit 6 unchanged.
- R7: A read of timer A counter index 4 or 5 clears flag bit 6.
- R8: A write to the flag bank clears each flag bit written as 1 and leaves the others unchanged. Bit 7 of the flag bank reads as 0.
- R9: A write to the enable bank with bit 7 set ORs in bits 6:0. A write with bit 7 clear clears every enable bit written as 1. Bit 7 of the enable bank reads as 0.
- R10: `irq` is high exactly when flag bit 2 and enable bit 2 are both set.
- R11: A pulse on `sr_event` sets flag bit 2. If it coincides with a flag-bank write that clears that bit, the set takes priority.
- R12: Leaving PERIODIC state stops further timer flag assertions. Timer A keeps counting and reloading as before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe, qualified by `bus_sel` |
| bus_rd | input | 1 | Read strobe, qualified by `bus_sel` |
| bus_addr | input | 13 | Byte address; bits 12:9 pick the register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| sr_event | input | 1 | Shift-complete pulse that sets flag bit 2 |
| irq | output | 1 | Interrupt request |

## Verification
The bench aligns its accesses to the divide-by-six phase, so it can predict exact counter bytes. A design that loads a whole counter on a byte write, or that steps on the wrong edge, returns bytes that do not match. Timer A is forced through zero with a small latch, which exposes an off-by-one reload as a wrong period and a missing read-clear as a flag that stays set. The bench also leaves periodic mode just before a wrap and checks that no flag appears while the counter still reloads. It then exercises the enable set and clear encodings and drives a shift event in the same cycle as a flag clear, so that a reversed priority or an interrupt tied to the wrong flag shows up on `irq`.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    typedef enum logic [3:0] {
        IDX_PORT_B    = 4'd0,
        IDX_PORT_A    = 4'd1,
        IDX_DIR_B     = 4'd2,
        IDX_DIR_A     = 4'd3,
        IDX_TA_LO     = 4'd4,
        IDX_TA_HI     = 4'd5,
        IDX_LATCH_LO  = 4'd6,
        IDX_LATCH_HI  = 4'd7,
        IDX_TB_LO     = 4'd8,
        IDX_TB_HI     = 4'd9,
        IDX_SHIFT     = 4'd10,
        IDX_AUX       = 4'd11,
        IDX_PERIPH    = 4'd12,
        IDX_FLAGS     = 4'd13,
        IDX_ENABLE    = 4'd14,
        IDX_PORT_A_NH = 4'd15
    } reg_idx_e;

    typedef enum logic {
        TA_QUIET    = 1'b0,
        TA_PERIODIC = 1'b1
    } ta_mode_e;

    localparam int          FLAG_BITS      = 7;
    localparam int          FLAG_SHIFT_POS = 2;
    localparam int          FLAG_TIMER_POS = 6;
    localparam logic [1:0]  MODE_PERIODIC  = 2'b01;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int DIV = 6
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (!rst_n)             phase_q <= '0;
        else if (phase_q == LAST) phase_q <= '0;
        else                    phase_q <= phase_q + 1'b1;
    end

    assign tick = (phase_q == LAST);

    generate
        if (DIV > 1) begin : g_gap
            AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick) else $error("tick repeated");            // R3
        end
    endgenerate

endmodule

// File: rtl/tmr_down_counter.sv
module tmr_down_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         ld_lo,
    input  logic         ld_hi,
    input  logic [7:0]   ld_byte,
    input  logic [W-1:0] reload,
    output logic [W-1:0] count,
    output logic         wrap
);
    logic [W-1:0] cnt_q;
    logic         loading;

    assign loading = ld_lo || ld_hi;
    assign wrap    = tick && (cnt_q == '0) && !loading;
    assign count   = cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '1;
        else if (ld_lo)  cnt_q <= {cnt_q[W-1:8], ld_byte};
        else if (ld_hi)  cnt_q <= {(W-8)'(ld_byte), cnt_q[7:0]};
        else if (wrap)   cnt_q <= reload;
        else if (tick)   cnt_q <= cnt_q - 1'b1;
    end

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !loading && count != '0) |=> count == $past(count) - 1'b1)
        else $error("bad step");                                          // R3
    AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !loading && count == '0) |=> count == $past(reload))
        else $error("bad reload");                                        // R5
    AST_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
        ld_lo |=> count[W-1:8] == $past(count[W-1:8]))
        else $error("high byte disturbed");                               // R4
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !loading) |=> $stable(count))
        else $error("count moved without tick");                          // R3

endmodule

// File: rtl/tmr_mode_fsm.sv
module tmr_mode_fsm
    import tick_timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       aux_wr,
    input  logic [1:0] mode_bits,
    input  logic       wrap,
    output logic       flag_set,
    output ta_mode_e   mode
);
    ta_mode_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TA_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TA_QUIET:    if (aux_wr && mode_bits == MODE_PERIODIC) state_d = TA_PERIODIC;
            TA_PERIODIC: if (aux_wr && mode_bits != MODE_PERIODIC) state_d = TA_QUIET;
            default:     state_d = TA_QUIET;
        endcase
    end

    always_comb begin
        flag_set = 1'b0;
        unique case (state_q)
            TA_QUIET:    flag_set = 1'b0;
            TA_PERIODIC: flag_set = wrap;
            default:     flag_set = 1'b0;
        endcase
    end

    assign mode = state_q;

    AST_ENTER_PERIODIC: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_wr && mode_bits == MODE_PERIODIC) |=> mode == TA_PERIODIC)
        else $error("mode not entered");                                  // R6
    AST_LEAVE_PERIODIC: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_wr && mode_bits != MODE_PERIODIC) |=> mode == TA_QUIET)
        else $error("mode not left");                                     // R12

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import tick_timer_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_flags,
    input  logic                 wr_enable,
    input  logic [7:0]           wdata,
    input  logic                 set_shift,
    input  logic                 set_timer,
    input  logic                 rd_clr_timer,
    output logic [FLAG_BITS-1:0] flags,
    output logic [FLAG_BITS-1:0] enables,
    output logic                 irq
);
    logic [FLAG_BITS-1:0] flag_q, flag_d, en_q, en_d;

    always_comb begin
        flag_d = flag_q;
        if (wr_flags)     flag_d = flag_d & ~wdata[FLAG_BITS-1:0];
        if (rd_clr_timer) flag_d[FLAG_TIMER_POS] = 1'b0;
        if (set_shift)    flag_d[FLAG_SHIFT_POS] = 1'b1;
        if (set_timer)    flag_d[FLAG_TIMER_POS] = 1'b1;
    end

    always_comb begin
        en_d = en_q;
        if (wr_enable) begin
            if (wdata[7]) en_d = en_q | wdata[FLAG_BITS-1:0];
            else          en_d = en_q & ~wdata[FLAG_BITS-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
            en_q   <= '0;
        end else begin
            flag_q <= flag_d;
            en_q   <= en_d;
        end
    end

    assign flags   = flag_q;
    assign enables = en_q;
    assign irq     = flag_q[FLAG_SHIFT_POS] & en_q[FLAG_SHIFT_POS];

    AST_TIMER_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set_timer |=> flags[FLAG_TIMER_POS])
        else $error("timer flag lost");                                   // R6
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr_timer && !set_timer) |=> !flags[FLAG_TIMER_POS])
        else $error("read clear failed");                                 // R7
    AST_SHIFT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_shift |=> flags[FLAG_SHIFT_POS])
        else $error("shift flag lost");                                   // R11
    AST_ENABLE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_enable && wdata[7]) |=> (enables & $past(wdata[FLAG_BITS-1:0])) == $past(wdata[FLAG_BITS-1:0]))
        else $error("enable set failed");                                 // R9
    AST_ENABLE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_enable && !wdata[7]) |=> (enables & $past(wdata[FLAG_BITS-1:0])) == '0)
        else $error("enable clear failed");                               // R9
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_flags && wdata[FLAG_SHIFT_POS] && !set_shift) |=> !irq)
        else $error("irq after clear");                                   // R10

endmodule

// File: rtl/tick_timer_regfile.sv
module tick_timer_regfile
    import tick_timer_pkg::*;
#(
    parameter int ADDR_W  = 13,
    parameter int IDX_LSB = 9,
    parameter int IDX_W   = 4,
    parameter int CNT_W   = 16,
    parameter int TICK_DIV = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              sr_event,
    output logic              irq
);
    localparam int LATCH_W = CNT_W + 1;
    localparam logic [LATCH_W-1:0] LATCH_RESET = LATCH_W'(1) << CNT_W;

    logic [IDX_W-1:0] idx;
    logic             wr_go, rd_go;
    logic             unused_addr_bits;

    assign idx   = bus_addr[IDX_LSB +: IDX_W];
    assign wr_go = bus_sel && bus_wr;
    assign rd_go = bus_sel && bus_rd;
    assign unused_addr_bits = ^bus_addr[IDX_LSB-1:0];

    function automatic logic hit(input logic [IDX_W-1:0] i, input reg_idx_e r);
        return i == IDX_W'(r);
    endfunction

    // Plain storage registers
    logic [7:0] port_b_q, port_a_q, dir_b_q, dir_a_q, shift_q, aux_q, periph_q, port_a_nh_q;
    logic [LATCH_W-1:0] latch_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_b_q    <= '0;
            port_a_q    <= '0;
            dir_b_q     <= '0;
            dir_a_q     <= '0;
            shift_q     <= '0;
            aux_q       <= '0;
            periph_q    <= '0;
            port_a_nh_q <= '0;
            latch_q     <= LATCH_RESET;
        end else if (wr_go) begin
            if (hit(idx, IDX_PORT_B))    port_b_q    <= bus_wdata;
            if (hit(idx, IDX_PORT_A))    port_a_q    <= bus_wdata;
            if (hit(idx, IDX_DIR_B))     dir_b_q     <= bus_wdata;
            if (hit(idx, IDX_DIR_A))     dir_a_q     <= bus_wdata;
            if (hit(idx, IDX_SHIFT))     shift_q     <= bus_wdata;
            if (hit(idx, IDX_AUX))       aux_q       <= bus_wdata;
            if (hit(idx, IDX_PERIPH))    periph_q    <= bus_wdata;
            if (hit(idx, IDX_PORT_A_NH)) port_a_nh_q <= bus_wdata;
            if (hit(idx, IDX_LATCH_LO))  latch_q     <= {1'b0, latch_q[CNT_W-1:8], bus_wdata};
            if (hit(idx, IDX_LATCH_HI))  latch_q     <= {1'b0, (CNT_W-8)'(bus_wdata), latch_q[7:0]};
        end
    end

    // Tick and counters
    logic             tick;
    logic [CNT_W-1:0] reload_a, count_a, count_b;
    logic             wrap_a, unused_wrap_b;

    assign reload_a = (latch_q == '0) ? '0 : CNT_W'(latch_q - 1'b1);

    tmr_prescaler #(.DIV(TICK_DIV)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    tmr_down_counter #(.W(CNT_W)) u_cnt_a (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .ld_lo   (wr_go && hit(idx, IDX_TA_LO)),
        .ld_hi   (wr_go && hit(idx, IDX_TA_HI)),
        .ld_byte (bus_wdata),
        .reload  (reload_a),
        .count   (count_a),
        .wrap    (wrap_a)
    );

    tmr_down_counter #(.W(CNT_W)) u_cnt_b (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .ld_lo   (wr_go && hit(idx, IDX_TB_LO)),
        .ld_hi   (wr_go && hit(idx, IDX_TB_HI)),
        .ld_byte (bus_wdata),
        .reload  ({CNT_W{1'b1}}),
        .count   (count_b),
        .wrap    (unused_wrap_b)
    );

    // Timer A mode machine
    logic     ta_flag_set;
    ta_mode_e ta_mode;

    tmr_mode_fsm u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .aux_wr    (wr_go && hit(idx, IDX_AUX)),
        .mode_bits (bus_wdata[7:6]),
        .wrap      (wrap_a),
        .flag_set  (ta_flag_set),
        .mode      (ta_mode)
    );

    // Flags and enables
    logic [FLAG_BITS-1:0] flags, enables;

    irq_flag_bank u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_flags     (wr_go && hit(idx, IDX_FLAGS)),
        .wr_enable    (wr_go && hit(idx, IDX_ENABLE)),
        .wdata        (bus_wdata),
        .set_shift    (sr_event),
        .set_timer    (ta_flag_set),
        .rd_clr_timer (rd_go && (hit(idx, IDX_TA_LO) || hit(idx, IDX_TA_HI))),
        .flags        (flags),
        .enables      (enables),
        .irq          (irq)
    );

    // Registered read path
    logic [7:0] rdata_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_go) begin
            unique case (reg_idx_e'(idx))
                IDX_PORT_B:    rdata_q <= port_b_q;
                IDX_PORT_A:    rdata_q <= port_a_q;
                IDX_DIR_B:     rdata_q <= dir_b_q;
                IDX_DIR_A:     rdata_q <= dir_a_q;
                IDX_TA_LO:     rdata_q <= count_a[7:0];
                IDX_TA_HI:     rdata_q <= 8'(count_a[CNT_W-1:8]);
                IDX_LATCH_LO:  rdata_q <= latch_q[7:0];
                IDX_LATCH_HI:  rdata_q <= 8'(latch_q[CNT_W-1:8]);
                IDX_TB_LO:     rdata_q <= count_b[7:0];
                IDX_TB_HI:     rdata_q <= 8'(count_b[CNT_W-1:8]);
                IDX_SHIFT:     rdata_q <= shift_q;
                IDX_AUX:       rdata_q <= aux_q;
                IDX_PERIPH:    rdata_q <= periph_q;
                IDX_FLAGS:     rdata_q <= {1'b0, flags};
                IDX_ENABLE:    rdata_q <= {1'b0, enables};
                IDX_PORT_A_NH: rdata_q <= port_a_nh_q;
                default:       rdata_q <= '0;
            endcase
        end
    end

    assign bus_rdata = rdata_q;

    AST_QUIET_NO_TIMER_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (ta_mode == TA_QUIET && !flags[FLAG_TIMER_POS]) |=> !flags[FLAG_TIMER_POS])
        else $error("timer flag in quiet mode");                          // R12
    AST_LATCH_WRITE_CLEARS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && (hit(idx, IDX_LATCH_LO) || hit(idx, IDX_LATCH_HI))) |=> !latch_q[CNT_W])
        else $error("latch top bit kept");                                // R5

endmodule

// File: tb/tick_timer_regfile_tb.sv
`timescale 1ns/1ps
module tick_timer_regfile_tb;
    import tick_timer_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [12:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        sr_event = 1'b0;
    logic        irq;

    int errors = 0;
    int checks = 0;
    int edge_n = 0;
    logic rd_q = 1'b0;
    bit  finished = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    tick_timer_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sr_event(sr_event), .irq(irq)
    );

    always @(posedge clk) begin
        if (rst_n) edge_n <= edge_n + 1;
        rd_q <= bus_sel && bus_rd;
    end

    // Monitor: compare each read result against the scoreboard
    always @(negedge clk) begin
        if (rd_q && exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (bus_rdata !== e) begin
                errors++;
                $display("FAIL %s: read got %02h expected %02h", t, bus_rdata, e);
            end
        end
    end

    task automatic wr(input reg_idx_e r, input logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_rd = 1'b0;
        bus_addr = {4'(r), 9'h1A5}; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input reg_idx_e r, input logic [7:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        bus_sel = 1'b1; bus_rd = 1'b1; bus_wr = 1'b0;
        bus_addr = {4'(r), 9'h05A};
        @(negedge clk);
        bus_sel = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string t);
        checks++;
        if (irq !== e) begin
            errors++;
            $display("FAIL %s: irq got %0b expected %0b", t, irq, e);
        end
    endtask

    task automatic align();
        do @(negedge clk); while (edge_n % 6 != 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R2: reset state
        chk_irq(1'b0, "R2 irq after reset");
        rd(IDX_TA_LO,    8'hFF, "R2 timer A low");
        rd(IDX_TA_HI,    8'hFF, "R2 timer A high");
        rd(IDX_TB_HI,    8'hFF, "R2 timer B high");
        rd(IDX_LATCH_LO, 8'h00, "R2 latch low");
        rd(IDX_LATCH_HI, 8'h00, "R2 latch high");
        rd(IDX_FLAGS,    8'h00, "R2 flags");
        rd(IDX_ENABLE,   8'h00, "R2 enables");

        // R3: free-running step every six clocks
        align();
        v = 16'hFFFF - 16'(edge_n / 6);
        rd(IDX_TA_LO, v[7:0], "R3 timer A low step");
        rd(IDX_TB_LO, v[7:0], "R3 timer B low step");
        repeat (6) @(negedge clk);
        v = 16'hFFFF - 16'(edge_n / 6);
        rd(IDX_TA_LO, v[7:0], "R3 timer A six clocks later");

        // R4: byte writes keep the other byte
        align();
        wr(IDX_TA_HI, 8'h12);
        wr(IDX_TA_LO, 8'h34);
        rd(IDX_TA_LO, 8'h34, "R4 low after write");
        rd(IDX_TA_HI, 8'h12, "R4 high after write");
        wr(IDX_TA_LO, 8'h56);
        rd(IDX_TA_HI, 8'h12, "R4 high kept after low write");
        rd(IDX_TA_LO, 8'h55, "R4 R3 low after one tick");

        // R5: timer B wraps to full scale
        align();
        wr(IDX_TB_HI, 8'h00);
        wr(IDX_TB_LO, 8'h00);
        rd(IDX_TB_LO, 8'h00, "R5 timer B at zero");
        align();
        rd(IDX_TB_LO, 8'hFF, "R5 timer B wrapped low");
        rd(IDX_TB_HI, 8'hFF, "R5 timer B wrapped high");

        // R5: timer A period equals latch (3), quiet mode sets no flag (R6)
        wr(IDX_LATCH_LO, 8'h03);
        wr(IDX_LATCH_HI, 8'h00);
        rd(IDX_LATCH_LO, 8'h03, "R5 latch low readback");
        align();
        wr(IDX_TA_HI, 8'h00);
        wr(IDX_TA_LO, 8'h00);
        align();
        rd(IDX_TA_LO, 8'h02, "R5 reload latch minus one");
        align();
        rd(IDX_TA_LO, 8'h01, "R5 period step 1");
        align();
        align();
        rd(IDX_TA_LO, 8'h02, "R5 period of three ticks");
        rd(IDX_FLAGS, 8'h00, "R6 no flag in quiet mode");

        // R6 / R7: periodic mode flag and read-clear
        wr(IDX_AUX, 8'h40);
        wr(IDX_LATCH_HI, 8'h10);
        align();
        wr(IDX_TA_HI, 8'h00);
        wr(IDX_TA_LO, 8'h00);
        align();
        rd(IDX_FLAGS, 8'h40, "R6 wrap sets timer flag");
        chk_irq(1'b0, "R10 timer flag does not drive irq");
        rd(IDX_TA_HI, 8'h10, "R7 R5 reload from latch");
        rd(IDX_FLAGS, 8'h00, "R7 counter read clears flag");

        // R12: leaving periodic mode stops flags, counter keeps reloading
        align();
        wr(IDX_TA_HI, 8'h00);
        wr(IDX_TA_LO, 8'h00);
        wr(IDX_AUX, 8'h00);
        align();
        rd(IDX_FLAGS, 8'h00, "R12 no flag after leaving mode");
        rd(IDX_TA_HI, 8'h10, "R12 counter still reloads");

        // R8 / R11: flag clear semantics
        wr(IDX_AUX, 8'h40);
        align();
        wr(IDX_TA_HI, 8'h00);
        wr(IDX_TA_LO, 8'h00);
        align();
        wr(IDX_AUX, 8'h00);
        sr_event = 1'b1;
        @(negedge clk);
        sr_event = 1'b0;
        rd(IDX_FLAGS, 8'h44, "R11 R8 both flags set");
        wr(IDX_FLAGS, 8'h40);
        rd(IDX_FLAGS, 8'h04, "R8 only written bit cleared");

        // R9 / R10: enable encodings and irq
        chk_irq(1'b0, "R10 flag set but not enabled");
        wr(IDX_ENABLE, 8'h84);
        chk_irq(1'b1, "R10 flag and enable set");
        rd(IDX_ENABLE, 8'h04, "R9 set encoding");
        wr(IDX_ENABLE, 8'hFB);
        rd(IDX_ENABLE, 8'h7F, "R9 OR in, bit 7 reads zero");
        wr(IDX_ENABLE, 8'h04);
        chk_irq(1'b0, "R10 enable cleared");
        rd(IDX_ENABLE, 8'h7B, "R9 clear encoding");
        wr(IDX_ENABLE, 8'h84);
        chk_irq(1'b1, "R10 enable restored");
        sr_event = 1'b1;
        wr(IDX_FLAGS, 8'h04);
        sr_event = 1'b0;
        chk_irq(1'b1, "R11 set beats clear");
        rd(IDX_FLAGS, 8'h04, "R11 flag survives clear");
        wr(IDX_FLAGS, 8'hFF);
        chk_irq(1'b0, "R10 R8 irq drops after clear");
        rd(IDX_FLAGS, 8'h00, "R8 all flags cleared");

        // R1: plain storage and index decode
        wr(IDX_PORT_B,    8'h11);
        wr(IDX_PORT_A,    8'hA5);
        wr(IDX_DIR_B,     8'h3C);
        wr(IDX_DIR_A,     8'hC3);
        wr(IDX_SHIFT,     8'h5A);
        wr(IDX_AUX,       8'h3C);
        wr(IDX_PERIPH,    8'h77);
        wr(IDX_PORT_A_NH, 8'h9E);
        rd(IDX_PORT_B,    8'h11, "R1 port B");
        rd(IDX_PORT_A,    8'hA5, "R1 port A");
        rd(IDX_DIR_B,     8'h3C, "R1 direction B");
        rd(IDX_DIR_A,     8'hC3, "R1 direction A");
        rd(IDX_SHIFT,     8'h5A, "R1 shift");
        rd(IDX_AUX,       8'h3C, "R1 aux control");
        rd(IDX_PERIPH,    8'h77, "R1 peripheral control");
        rd(IDX_PORT_A_NH, 8'h9E, "R1 port A no handshake");

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule